// File: doc/BRIEF.md
# Serial Trace Byte Port

The block is a one-way debug output for an embedded processor. Software writes a byte into the data register over a simple 32-bit register bus, and the block sends that byte out on two pins, a shift clock and a data line, least significant bit first. Nothing comes back in on these pins. When no byte is being sent, both pins sit at logic 1.

The shift clock runs at half the bus clock rate, so each bit takes two bus cycles. A byte therefore takes sixteen bus cycles. A bit in the control register picks which edge of the shift clock changes the data. The data is always stable across the other edge, which is the edge an external capture device samples on.

A data write that arrives while a byte is still being sent is not dropped and is not queued. The block holds the bus off by keeping `bus_ready` low until the current byte has finished, and then accepts the write.

Top module: `serial_trace_port`

## Requirements
- R1: After reset, `ser_clk` and `ser_dat` are 1, the data register (offset 0x00) reads 0x00 and the control register (offset 0x04) reads 0.
- R2: A data-register write while idle completes in the cycle it is presented (`bus_ready`=1). From the next cycle the busy flag, control bit 1, reads 1.
- R3: The accepted byte appears on `ser_dat` bit 0 first. In the cycles numbered 1 to 16 after the accepting edge, bit k is driven during cycles 2k+1 and 2k+2.
- R4: With control bit 0 (edge select) at 0, `ser_clk` is 1 in odd cycles and 0 in even cycles of the transfer. Data changes only as the clock goes high and is stable across every falling edge.
- R5: With edge select at 1, `ser_clk` is 0 in odd cycles and 1 in even cycles. Data changes only as the clock goes low and is stable across every rising edge.
- R6: In cycle 17 after the accepting edge, both lines are back at 1 and the busy flag reads 0. Whenever the block is not busy, both lines are 1.
- R7: A data-register write issued while busy keeps `bus_ready` at 0 until the busy flag clears. When the write follows the accepting edge by one cycle, it waits exactly 16 cycles and is then accepted.
- R8: A data-register read returns the last accepted byte in bits 7:0 and 0 in the other bits. A held-off write does not change it until it is accepted.
- R9: Control bit 0 can be read and written. Bit 1 is the read-only busy flag. Bits 31:2 read 0.
- R10: A control write completes at once even while busy. A new edge select takes effect from the next byte and does not alter the byte in flight.
- R11: Accesses to other word offsets complete at once. Reads there return 0, and writes there change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the source of the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is requested |
| bus_ready | output | 1 | Access completes on the clock edge where this is 1 |
| ser_clk | output | 1 | Serial shift clock, idle 1 |
| ser_dat | output | 1 | Serial data, LSB first, idle 1 |

## Verification
The embedded properties check on every cycle the following:
- Data stays stable across the sampling edge for each edge select.
- Both lines are high whenever the block is idle.
- An accepted write raises busy.
- A write held off while busy leaves the data register unchanged.
- Reserved and unmapped reads return zero.

The bench scenarios show the rest:
- The exact bit order and the cycle-by-cycle clock pattern for each edge select.
- The 16-cycle hold-off length and the transfer that follows it.
- That an edge select changed mid-byte waits for the next byte.
- That the last written value is read back.

// File: rtl/serial_trace_port.sv
module serial_trace_port #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              ser_clk,
  output logic              ser_dat
);
  localparam int STEPS = 2 * BYTE_W;
  localparam int CNT_W = $clog2(STEPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic [BYTE_W-1:0] data_q;
  logic              edge_sel_q, edge_run_q, busy_q;
  logic [CNT_W-1:0]  step_q;
  logic              clk_q, dat_q;

  wire hit_data = (bus_addr[ADDR_W-1:2] == '0);
  wire hit_ctrl = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign bus_ready = bus_req && !(bus_wr && hit_data && busy_q);
  wire do_wr     = bus_req && bus_wr && bus_ready;
  wire take_byte = do_wr && hit_data;
  wire set_ctrl  = do_wr && hit_ctrl;
  wire [CNT_W-1:0] step_nx = step_q + 1'b1;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:BYTE_W], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      edge_sel_q <= 1'b0;
      edge_run_q <= 1'b0;
      busy_q     <= 1'b0;
      step_q     <= '0;
      clk_q      <= 1'b1;
      dat_q      <= 1'b1;
    end else begin
      if (set_ctrl) edge_sel_q <= bus_wdata[0];
      if (take_byte) begin
        data_q     <= bus_wdata[BYTE_W-1:0];
        edge_run_q <= edge_sel_q;
        busy_q     <= 1'b1;
        step_q     <= '0;
        clk_q      <= ~edge_sel_q;
        dat_q      <= bus_wdata[0];
      end else if (busy_q) begin
        if (step_q == LAST) begin
          busy_q <= 1'b0;
          step_q <= '0;
          clk_q  <= 1'b1;
          dat_q  <= 1'b1;
        end else begin
          step_q <= step_nx;
          clk_q  <= edge_run_q ^ ~step_nx[0];
          dat_q  <= data_q[step_nx[CNT_W-1:1]];
        end
      end
    end
  end

  assign ser_clk = clk_q;
  assign ser_dat = dat_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_wr) begin
      if (hit_data)      bus_rdata[BYTE_W-1:0] = data_q;
      else if (hit_ctrl) bus_rdata[1:0] = {busy_q, edge_sel_q};
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |=> busy_q && (ser_dat == $past(bus_wdata[0])));
  p_hold_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !edge_run_q && $fell(ser_clk)) |-> $stable(ser_dat));
  p_hold_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && edge_run_q && $rose(ser_clk)) |-> $stable(ser_dat));
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (ser_clk && ser_dat));
  p_holdoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && hit_data && busy_q) |=> $stable(data_q));
  p_ctrl_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && hit_ctrl) |-> (bus_rdata[31:2] == '0));
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !hit_data && !hit_ctrl) |-> (bus_ready && bus_rdata == '0));
endmodule

// File: tb/tb_serial_trace_port.sv
module tb_serial_trace_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_ready, ser_clk, ser_dat;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  serial_trace_port dut (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .ser_clk(ser_clk), .ser_dat(ser_dat));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_clk(input int c, input bit e);
    return (c % 2 == 0) ? ~e : e;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output int waits);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; waits = 0;
    #1;
    while (!bus_ready) begin waits++; @(negedge clk); #1; end
    @(posedge clk); #1;
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    #1;
    d = bus_rdata;
    check(bus_ready, "R11", "read ready", bus_ready, 1);
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic capture(input logic [7:0] b, input bit e, input string req);
    bit mism = 0;
    logic [7:0] got = '0;
    for (int i = 1; i <= 17; i++) begin
      @(negedge clk);
      if (i <= 16) begin
        if (ser_clk !== exp_clk(i - 1, e)) mism = 1;
        if (ser_dat !== b[(i - 1) / 2]) mism = 1;
        got[(i - 1) / 2] = ser_dat;
      end else begin
        check(ser_clk === 1 && ser_dat === 1, "R6", "lines idle after byte",
              {ser_clk, ser_dat}, 2'b11);
      end
    end
    check(!mism, req, "serial waveform/byte", got, b);
  endtask

  task automatic send(input logic [7:0] b, input bit e, input string req);
    int w;
    bus_write(8'h00, {24'h0, b}, w);
    check(w == 0, "R2", "idle data write waits", w, 0);
    capture(b, e, req);
  endtask

  initial begin
    logic [31:0] rd;
    int w;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(ser_clk === 1 && ser_dat === 1, "R1", "reset lines", {ser_clk, ser_dat}, 2'b11);
    rst_n = 1;
    bus_read(8'h00, rd); check(rd == 0, "R1", "data reset", rd, 0);
    bus_read(8'h04, rd); check(rd == 0, "R1", "ctrl reset", rd, 0);

    send(8'hA5, 0, "R3");
    send(8'h01, 0, "R4");
    bus_read(8'h00, rd); check(rd == 32'h01, "R8", "data readback", rd, 32'h01);

    bus_write(8'h04, 32'hFFFF_FFFF, w);
    bus_read(8'h04, rd); check(rd == 32'h1, "R9", "ctrl readback", rd, 1);
    send(8'h80, 1, "R5");
    bus_write(8'h04, 32'h0, w);

    bus_write(8'h00, 32'h3C, w);
    bus_read(8'h04, rd); check(rd == 32'h2, "R2", "busy flag set", rd, 2);
    repeat (18) @(negedge clk);
    bus_read(8'h04, rd); check(rd == 32'h0, "R6", "busy flag clear", rd, 0);

    bus_write(8'h00, 32'h96, w);
    fork
      capture(8'h96, 0, "R7");
      begin
        int w2;
        bus_write(8'h00, 32'h5A, w2);
        check(w2 == 16, "R7", "hold-off cycles", w2, 16);
      end
    join
    capture(8'h5A, 0, "R7");
    bus_read(8'h00, rd); check(rd == 32'h5A, "R8", "held write landed", rd, 32'h5A);

    bus_write(8'h00, 32'hC3, w);
    fork
      capture(8'hC3, 0, "R10");
      begin
        int w3;
        @(negedge clk);
        bus_write(8'h04, 32'h1, w3);
        check(w3 == 0, "R10", "ctrl write while busy", w3, 0);
      end
    join
    send(8'hC3, 1, "R10");

    bus_read(8'h08, rd); check(rd == 0, "R11", "unmapped read", rd, 0);
    bus_write(8'h0C, 32'hFFFF_FFFE, w);
    check(w == 0, "R11", "unmapped write ready", w, 0);
    bus_read(8'h00, rd); check(rd == 32'hC3, "R11", "data untouched", rd, 32'hC3);
    bus_read(8'h04, rd); check(rd == 32'h1, "R11", "ctrl untouched", rd, 1);

    for (int k = 0; k < 24; k++) begin
      logic [7:0] b;
      bit e;
      b = 8'($urandom);
      e = 1'($urandom);
      bus_write(8'h04, {31'h0, e}, w);
      send(b, e, e ? "R5" : "R4");
      bus_read(8'h00, rd); check(rd == {24'h0, b}, "R8", "random readback", rd, b);
      bus_read(8'h04, rd); check(rd == {31'h0, e}, "R9", "random ctrl", rd, e);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule